// File: doc/BRIEF.md
# Safety Supervisor Fault-Reaction Controller

This block watches a set of fault indications around an external microcontroller in a motor-inverter supply and decides how hard to react. It drives three outputs: an active-low MCU reset, an active-low power-stage (safing path) enable, and a regulator enable. It has four operating states. In ACTIVE the MCU runs and the power stage may switch. RESET holds the MCU in reset. SAFE keeps the MCU alive but drops the power stage. STANDBY switches the regulators off.

Each fault class has its own reaction. The main battery and safing-monitor undervoltages and overtemperature cause the block to power down. An I/O-supply undervoltage causes a reset. A core-supply fault or a watchdog failure causes a reset only when its enable bit is set. An MCU error-signal failure, and a reset-pin mismatch when its monitor is enabled, send the block to SAFE. A saturating error counter counts SAFE entries and decides whether SAFE escalates, recovers through RESET or stays locked.

The driven reset and enable pins are read back and compared with their intended levels. A mismatch counts only if it persists. Every fault leaves a sticky status bit that software reads through a clear-on-read port.

Top module: `sup_fault_ctrl`

## Requirements
- R1: After `rst_ni` is released the block stays in RESET for RST_HOLD cycles and then enters ACTIVE. In RESET, `nres_o`=0, `endrv_o`=0 and `reg_en_o`=1. In ACTIVE all three outputs are 1. While `rst_ni` is low, `rd_data_o` reads 0.
- R2: From any state other than STANDBY, `vbat_uv_i`, `safing_uv_i` or `otemp_i` moves the block to STANDBY on the next edge. In STANDBY all three outputs are 0.
- R3: In ACTIVE or SAFE, `io_uv_i` moves the block to RESET on the next edge. After any entry to RESET, the block stays there for RST_HOLD cycles and then returns to ACTIVE.
- R4: `core_uv_i` or `core_ov_i` in ACTIVE moves the block to RESET only when `cfg_core_rst_en_i`=1. Status bit 3 is set in either case.
- R5: `wd_fail_i` in ACTIVE moves the block to RESET only when `cfg_wd_rst_en_i`=1. Status bit 4 is set in either case.
- R6: `esm_fail_i` in ACTIVE moves the block to SAFE, where `nres_o`=1, `endrv_o`=0 and `reg_en_o`=1. Each entry to SAFE increments the error counter, which saturates at `cfg_err_limit_i`.
- R7: SAFE lasts SAFE_DWELL cycles. Then, if the counter has reached `cfg_err_limit_i`, the block goes to STANDBY when `cfg_esc_stby_i`=1 and to RESET otherwise. Below the limit, it stays locked in SAFE when `cfg_safe_lock_i`=1 and goes to RESET otherwise.
- R8: A difference between `nres_sense_i` and `nres_o` that persists for FILT_CYC consecutive cycles sets status bit 6. If `cfg_nres_mon_en_i`=1 and the block is in ACTIVE, it also moves the block to SAFE. A shorter difference has no effect.
- R9: A difference between `endrv_sense_i` and `endrv_o` that persists for FILT_CYC cycles sets status bit 7 and does not change the state.
- R10: Status bits are sticky. Bit 0 is vbat_uv, 1 safing_uv, 2 io_uv, 3 core uv/ov, 4 wd_fail, 5 esm_fail, 6 nres mismatch, 7 endrv mismatch and 8 otemp. A pulse on `rd_en_i` loads `rd_data_o` = {error counter, status} on that edge and clears the status bits. A bit that is being set on the same edge survives the clear.
- R11: STANDBY is left only when `wake_i` is 1, and the block then enters RESET. The error counter survives STANDBY and is cleared only by `rst_ni`.
- R12: Simultaneous faults resolve by priority: the STANDBY class wins over the RESET class, which wins over the SAFE class. A SAFE-class fault that loses does not increment the error counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| vbat_uv_i | input | 1 | Main battery undervoltage |
| safing_uv_i | input | 1 | Safing monitor supply undervoltage |
| otemp_i | input | 1 | Overtemperature |
| io_uv_i | input | 1 | I/O supply undervoltage |
| core_uv_i | input | 1 | Core supply undervoltage |
| core_ov_i | input | 1 | Core supply overvoltage |
| wd_fail_i | input | 1 | Watchdog failure |
| esm_fail_i | input | 1 | MCU error-signal failure |
| wake_i | input | 1 | Wake request that leaves STANDBY |
| nres_sense_i | input | 1 | Read-back of the reset pin |
| endrv_sense_i | input | 1 | Read-back of the power-stage enable pin |
| cfg_core_rst_en_i | input | 1 | Core fault causes RESET |
| cfg_wd_rst_en_i | input | 1 | Watchdog failure causes RESET |
| cfg_nres_mon_en_i | input | 1 | Reset-pin mismatch causes SAFE |
| cfg_safe_lock_i | input | 1 | Stay locked in SAFE below the error limit |
| cfg_esc_stby_i | input | 1 | Escalate to STANDBY (1) or RESET (0) at the limit |
| cfg_err_limit_i | input | ERR_CNT_W | Error counter threshold (at least 1) |
| rd_en_i | input | 1 | Status read strobe, clears the status bits |
| rd_data_o | output | 9+ERR_CNT_W | {error counter, status bits} |
| nres_o | output | 1 | Active-low MCU reset |
| endrv_o | output | 1 | Active-high power-stage enable (low means safe) |
| reg_en_o | output | 1 | Regulator enable |

## Verification
On every cycle, the assertions check the next-edge reactions to the STANDBY, RESET and SAFE fault classes and that ACTIVE holds when no fault is present. They also check that STANDBY is held while no wake is given, that the counter only moves on a SAFE entry, that a flagged mismatch was really present, and the sticky and clear-on-read rules of the status bits. The bench scenarios cover the timed behaviour: the lengths of the RESET hold and the SAFE dwell, and the escalation outcome across every combination of error limit, lock and escalation target. They also show that a counter value is retained across STANDBY, that mismatch pulses one cycle shorter than the filter are rejected, and that a bit set on the same edge as a read survives the clear.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_SAFE    = 2'd2,
        ST_STANDBY = 2'd3
    } sup_state_e;

    localparam int STAT_W     = 9;
    localparam int B_VBAT_UV  = 0;
    localparam int B_SAFE_UV  = 1;
    localparam int B_IO_UV    = 2;
    localparam int B_CORE     = 3;
    localparam int B_WD       = 4;
    localparam int B_ESM      = 5;
    localparam int B_NRES_ERR = 6;
    localparam int B_ENDRV_ERR = 7;
    localparam int B_OTEMP    = 8;

    localparam int NUM_PINS   = 2;
    localparam int PIN_NRES   = 0;
    localparam int PIN_ENDRV  = 1;
endpackage

// File: rtl/sup_pin_filter.sv
module sup_pin_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic driven_i,
    input  logic sensed_i,
    output logic flag_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          diff;

    assign diff = driven_i ^ sensed_i;

    always_comb begin
        cnt_d = cnt_q;
        if (!diff) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign flag_o = (cnt_q == LIMIT);

    // R8
    pin_persist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_o |-> $past(driven_i ^ sensed_i));
endmodule

// File: rtl/sup_err_cnt.sv
module sup_err_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) begin
            if (cnt_q < limit_i) cnt_d = cnt_q + 1'b1;
            else                 cnt_d = limit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R11
    cnt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inc_i |=> $stable(cnt_o));

    // R6
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && (cnt_o < limit_i)) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/sup_status.sv
module sup_status #(
    parameter int STAT_W = 9,
    parameter int CNT_W  = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [STAT_W-1:0]       set_i,
    input  logic                    rd_en_i,
    input  logic [CNT_W-1:0]        err_cnt_i,
    output logic [STAT_W-1:0]       stat_o,
    output logic [STAT_W+CNT_W-1:0] rd_data_o
);
    localparam int RD_W = STAT_W + CNT_W;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [RD_W-1:0]   rd;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_en_i) begin
            s_d.rd   = {err_cnt_i, s_q.stat};
            s_d.stat = set_i;
        end else begin
            s_d.stat = s_q.stat | set_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign stat_o    = s_q.stat;
    assign rd_data_o = s_q.rd;

    // R10
    sticky_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // R10
    read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> ((stat_o & ~$past(set_i)) == '0));
endmodule

// File: rtl/sup_fault_ctrl.sv
module sup_fault_ctrl
    import sup_pkg::*;
#(
    parameter int RST_HOLD   = 8,
    parameter int SAFE_DWELL = 6,
    parameter int FILT_CYC   = 4,
    parameter int ERR_CNT_W  = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        vbat_uv_i,
    input  logic                        safing_uv_i,
    input  logic                        otemp_i,
    input  logic                        io_uv_i,
    input  logic                        core_uv_i,
    input  logic                        core_ov_i,
    input  logic                        wd_fail_i,
    input  logic                        esm_fail_i,
    input  logic                        wake_i,
    input  logic                        nres_sense_i,
    input  logic                        endrv_sense_i,
    input  logic                        cfg_core_rst_en_i,
    input  logic                        cfg_wd_rst_en_i,
    input  logic                        cfg_nres_mon_en_i,
    input  logic                        cfg_safe_lock_i,
    input  logic                        cfg_esc_stby_i,
    input  logic [ERR_CNT_W-1:0]        cfg_err_limit_i,
    input  logic                        rd_en_i,
    output logic [STAT_W+ERR_CNT_W-1:0] rd_data_o,
    output logic                        nres_o,
    output logic                        endrv_o,
    output logic                        reg_en_o
);
    localparam int HOLD_W  = (RST_HOLD   > 1) ? $clog2(RST_HOLD)   : 1;
    localparam int DWELL_W = (SAFE_DWELL > 1) ? $clog2(SAFE_DWELL) : 1;
    localparam logic [HOLD_W-1:0]  HOLD_LAST  = HOLD_W'(RST_HOLD - 1);
    localparam logic [DWELL_W-1:0] DWELL_LAST = DWELL_W'(SAFE_DWELL - 1);

    typedef struct packed {
        sup_state_e         state;
        logic [HOLD_W-1:0]  hold;
        logic [DWELL_W-1:0] dwell;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic                 stby_flt, rst_flt, safe_flt, core_flt;
    logic                 safe_enter;
    logic [NUM_PINS-1:0]  pin_drv, pin_sns, pin_flag;
    logic [STAT_W-1:0]    stat_set, stat_q;
    logic [ERR_CNT_W-1:0] err_cnt;

    // pin read-back monitors, one per supervised pin
    assign pin_drv[PIN_NRES]  = nres_o;
    assign pin_drv[PIN_ENDRV] = endrv_o;
    assign pin_sns[PIN_NRES]  = nres_sense_i;
    assign pin_sns[PIN_ENDRV] = endrv_sense_i;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        sup_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .driven_i (pin_drv[p]),
            .sensed_i (pin_sns[p]),
            .flag_o   (pin_flag[p])
        );
    end

    // fault classification
    assign core_flt = core_uv_i | core_ov_i;
    assign stby_flt = vbat_uv_i | safing_uv_i | otemp_i;
    assign rst_flt  = io_uv_i | (core_flt & cfg_core_rst_en_i)
                    | (wd_fail_i & cfg_wd_rst_en_i);
    assign safe_flt = esm_fail_i | (pin_flag[PIN_NRES] & cfg_nres_mon_en_i);

    // status set vector
    always_comb begin
        stat_set              = '0;
        stat_set[B_VBAT_UV]   = vbat_uv_i;
        stat_set[B_SAFE_UV]   = safing_uv_i;
        stat_set[B_IO_UV]     = io_uv_i;
        stat_set[B_CORE]      = core_flt;
        stat_set[B_WD]        = wd_fail_i;
        stat_set[B_ESM]       = esm_fail_i;
        stat_set[B_NRES_ERR]  = pin_flag[PIN_NRES];
        stat_set[B_ENDRV_ERR] = pin_flag[PIN_ENDRV];
        stat_set[B_OTEMP]     = otemp_i;
    end

    // state machine next-value logic
    always_comb begin
        c_d        = c_q;
        safe_enter = 1'b0;
        unique case (c_q.state)
            ST_RESET: begin
                if (stby_flt)                c_d.state = ST_STANDBY;
                else if (c_q.hold == HOLD_LAST) c_d.state = ST_ACTIVE;
                else                         c_d.hold  = c_q.hold + 1'b1;
            end
            ST_ACTIVE: begin
                if (stby_flt)      c_d.state = ST_STANDBY;
                else if (rst_flt)  c_d.state = ST_RESET;
                else if (safe_flt) begin
                    c_d.state  = ST_SAFE;
                    safe_enter = 1'b1;
                end
            end
            ST_SAFE: begin
                if (stby_flt)                      c_d.state = ST_STANDBY;
                else if (rst_flt)                  c_d.state = ST_RESET;
                else if (c_q.dwell != DWELL_LAST)  c_d.dwell = c_q.dwell + 1'b1;
                else if (err_cnt >= cfg_err_limit_i)
                    c_d.state = cfg_esc_stby_i ? ST_STANDBY : ST_RESET;
                else if (!cfg_safe_lock_i)         c_d.state = ST_RESET;
            end
            ST_STANDBY: begin
                if (wake_i) c_d.state = ST_RESET;
            end
            default: c_d.state = ST_RESET;
        endcase
        if (c_d.state != c_q.state) begin
            c_d.hold  = '0;
            c_d.dwell = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '{state: ST_RESET, hold: '0, dwell: '0};
        else         c_q <= c_d;
    end

    sup_err_cnt #(.CNT_W(ERR_CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (safe_enter),
        .limit_i (cfg_err_limit_i),
        .cnt_o   (err_cnt)
    );

    sup_status #(.STAT_W(STAT_W), .CNT_W(ERR_CNT_W)) u_stat (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (stat_set),
        .rd_en_i   (rd_en_i),
        .err_cnt_i (err_cnt),
        .stat_o    (stat_q),
        .rd_data_o (rd_data_o)
    );

    assign nres_o   = (c_q.state == ST_ACTIVE) || (c_q.state == ST_SAFE);
    assign endrv_o  = (c_q.state == ST_ACTIVE);
    assign reg_en_o = (c_q.state != ST_STANDBY);

    // R2
    stby_react_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stby_flt && reg_en_o) |=> (!reg_en_o && !nres_o && !endrv_o));

    // R3
    io_react_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_uv_i && !stby_flt && nres_o) |=> (reg_en_o && !nres_o && !endrv_o));

    // R4 R5
    active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (endrv_o && !stby_flt && !rst_flt && !safe_flt) |=> (endrv_o && nres_o));

    // R6 R12
    safe_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (endrv_o && esm_fail_i && !stby_flt && !rst_flt) |=> (nres_o && !endrv_o && reg_en_o));

    // R11
    stby_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reg_en_o && !wake_i) |=> !reg_en_o);

    // R10
    stat_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_set != '0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));
endmodule

// File: tb/tb_sup_fault_ctrl.sv
module tb_sup_fault_ctrl;
    localparam int RST_HOLD   = 8;
    localparam int SAFE_DWELL = 6;
    localparam int FILT_CYC   = 4;
    localparam int CW         = 3;
    localparam int RD_W       = 9 + CW;

    localparam logic [2:0] S_ACT  = 3'b111;
    localparam logic [2:0] S_RST  = 3'b001;
    localparam logic [2:0] S_SAFE = 3'b101;
    localparam logic [2:0] S_STBY = 3'b000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vbat_uv = 0, safing_uv = 0, otemp = 0, io_uv = 0, core_uv = 0, core_ov = 0;
    logic wd_fail = 0, esm_fail = 0, wake = 0, rd_en = 0;
    logic cfg_core = 0, cfg_wd = 0, cfg_nmon = 0, cfg_lock = 0, cfg_esc = 0;
    logic [CW-1:0] cfg_lim = 3'd2;
    logic nres_frc = 0, nres_fv = 0, endrv_frc = 0, endrv_fv = 0;
    logic nres_sense, endrv_sense;
    logic [RD_W-1:0] rd_data;
    logic nres, endrv, reg_en;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    assign nres_sense  = nres_frc  ? nres_fv  : nres;
    assign endrv_sense = endrv_frc ? endrv_fv : endrv;

    sup_fault_ctrl #(.RST_HOLD(RST_HOLD), .SAFE_DWELL(SAFE_DWELL),
                     .FILT_CYC(FILT_CYC), .ERR_CNT_W(CW)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .vbat_uv_i(vbat_uv), .safing_uv_i(safing_uv), .otemp_i(otemp),
        .io_uv_i(io_uv), .core_uv_i(core_uv), .core_ov_i(core_ov),
        .wd_fail_i(wd_fail), .esm_fail_i(esm_fail), .wake_i(wake),
        .nres_sense_i(nres_sense), .endrv_sense_i(endrv_sense),
        .cfg_core_rst_en_i(cfg_core), .cfg_wd_rst_en_i(cfg_wd),
        .cfg_nres_mon_en_i(cfg_nmon), .cfg_safe_lock_i(cfg_lock),
        .cfg_esc_stby_i(cfg_esc), .cfg_err_limit_i(cfg_lim),
        .rd_en_i(rd_en), .rd_data_o(rd_data),
        .nres_o(nres), .endrv_o(endrv), .reg_en_o(reg_en)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] st();
        return {13'd0, nres, endrv, reg_en};
    endfunction

    task automatic rd(output logic [RD_W-1:0] d);
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic powerup();
        rst_n = 1'b0;
        tick(2);
        chk("R1 reset outputs", st(), S_RST);
        chk("R1 reset read data", 16'(rd_data), 16'd0);
        rst_n = 1'b1;
        tick(RST_HOLD - 1);
        chk("R1 still held", st(), S_RST);
        tick(1);
        chk("R1 active after hold", st(), S_ACT);
    endtask

    task automatic pulse_mismatch(bit on_nres, int n);
        if (on_nres) begin nres_fv = ~nres; nres_frc = 1'b1; end
        else         begin endrv_fv = ~endrv; endrv_frc = 1'b1; end
        tick(n);
        nres_frc = 1'b0;
        endrv_frc = 1'b0;
        tick(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [RD_W-1:0] d;
        tick(1);
        powerup();
        rd(d);
        chk("R10 clean after power-up", 16'(d), 16'd0);

        // R2: each STANDBY-class input
        for (int s = 0; s < 3; s++) begin
            vbat_uv = (s == 0); safing_uv = (s == 1); otemp = (s == 2);
            tick(1);
            vbat_uv = 0; safing_uv = 0; otemp = 0;
            chk("R2 standby entry", st(), S_STBY);
            tick(3);
            chk("R11 standby held without wake", st(), S_STBY);
            wake = 1; tick(1); wake = 0;
            chk("R11 wake enters reset", st(), S_RST);
            tick(RST_HOLD);
            chk("R3 reset hold to active", st(), S_ACT);
            rd(d);
            chk("R10 standby cause bit", 16'(d[8:0]),
                16'(s == 0 ? 9'h001 : (s == 1 ? 9'h002 : 9'h100)));
        end

        // R3: io undervoltage
        io_uv = 1; tick(1); io_uv = 0;
        chk("R3 io uv reset", st(), S_RST);
        tick(RST_HOLD - 1);
        chk("R3 reset hold length", st(), S_RST);
        tick(1);
        chk("R3 back to active", st(), S_ACT);
        rd(d);
        chk("R3 io bit", 16'(d[8:0]), 16'h004);

        // R4 R5: sweep masked fault source and enable
        for (int sel = 0; sel < 3; sel++) begin
            for (int en = 0; en < 2; en++) begin
                cfg_core = en[0]; cfg_wd = en[0];
                core_uv = (sel == 0); core_ov = (sel == 1); wd_fail = (sel == 2);
                tick(1);
                core_uv = 0; core_ov = 0; wd_fail = 0;
                chk(sel == 2 ? "R5 watchdog reaction" : "R4 core reaction",
                    st(), en ? S_RST : S_ACT);
                if (en) tick(RST_HOLD);
                rd(d);
                chk(sel == 2 ? "R5 watchdog bit" : "R4 core bit",
                    16'(d[8:0]), sel == 2 ? 16'h010 : 16'h008);
            end
        end
        cfg_core = 0; cfg_wd = 0;

        // R10: set on the same edge as a read survives
        wd_fail = 1; rd_en = 1; tick(1); wd_fail = 0; rd_en = 0;
        chk("R10 read before set", 16'(rd_data[8:0]), 16'h000);
        rd(d);
        chk("R10 set wins over clear", 16'(d[8:0]), 16'h010);
        rd(d);
        chk("R10 cleared after read", 16'(d[8:0]), 16'h000);

        // R8: nres mismatch filter, monitor on and off
        cfg_nmon = 1;
        pulse_mismatch(1'b1, FILT_CYC - 1);
        chk("R8 short glitch no state change", st(), S_ACT);
        rd(d);
        chk("R8 short glitch no bit", 16'(d[8:0]), 16'h000);
        pulse_mismatch(1'b1, FILT_CYC);
        chk("R8 persistent mismatch to safe", st(), S_SAFE);
        rd(d);
        chk("R8 nres bit", 16'(d[8:0]), 16'h040);
        powerup();
        cfg_nmon = 0;
        pulse_mismatch(1'b1, FILT_CYC);
        chk("R8 monitor off stays active", st(), S_ACT);
        rd(d);
        chk("R8 bit set with monitor off", 16'(d[8:0]), 16'h040);

        // R9: endrv read-back
        pulse_mismatch(1'b0, FILT_CYC - 1);
        rd(d);
        chk("R9 short glitch no bit", 16'(d[8:0]), 16'h000);
        pulse_mismatch(1'b0, FILT_CYC);
        chk("R9 no state change", st(), S_ACT);
        rd(d);
        chk("R9 endrv bit", 16'(d[8:0]), 16'h080);

        // R12: priorities
        esm_fail = 1; io_uv = 1; vbat_uv = 1; tick(1);
        esm_fail = 0; io_uv = 0; vbat_uv = 0;
        chk("R12 standby wins", st(), S_STBY);
        wake = 1; tick(1); wake = 0; tick(RST_HOLD);
        esm_fail = 1; io_uv = 1; tick(1); esm_fail = 0; io_uv = 0;
        chk("R12 reset beats safe", st(), S_RST);
        tick(RST_HOLD);
        rd(d);
        chk("R12 counter untouched", 16'(d[RD_W-1:9]), 16'd0);

        // R6 R7 R11: escalation sweep over limit, lock and target
        for (int lim = 1; lim <= 3; lim++) begin
            for (int lk = 0; lk < 2; lk++) begin
                for (int es = 0; es < 2; es++) begin
                    cfg_lim = CW'(lim); cfg_lock = lk[0]; cfg_esc = es[0];
                    powerup();
                    for (int k = 1; k <= lim + 1; k++) begin
                        int expc;
                        logic [2:0] exps;
                        expc = (k < lim) ? k : lim;
                        if (expc >= lim) exps = es ? S_STBY : S_RST;
                        else             exps = lk ? S_SAFE : S_RST;
                        esm_fail = 1; tick(1); esm_fail = 0;
                        chk("R6 safe outputs", st(), S_SAFE);
                        tick(SAFE_DWELL - 1);
                        chk("R7 safe dwell", st(), S_SAFE);
                        tick(1);
                        chk("R7 safe exit", st(), 16'(exps));
                        if (exps == S_STBY) begin
                            wake = 1; tick(1); wake = 0;
                        end else if (exps == S_SAFE) begin
                            io_uv = 1; tick(1); io_uv = 0;
                        end
                        tick(RST_HOLD);
                        rd(d);
                        chk("R6 counter saturating", 16'(d[RD_W-1:9]), 16'(expc));
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule